// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Master Bit Engine

This block drives the clock and data lines of a two-wire serial bus (I2C) at the level of single bus primitives. Each line is open-drain. The engine owns one pull-low enable per line and reads the real line level back through an input. It never drives a line high. A released line is assumed to be pulled high by an external resistor.

A sequencer above the block issues one primitive at a time: a start condition, a stop condition, a byte write, or a byte read with a chosen acknowledge response. The block reports that it is busy while it works. When it finishes it pulses done for one cycle. It presents the byte it received and the acknowledge level that a slave returned.

A divider input sets the quarter-bit period in system clocks. Every rising clock edge the engine makes is a release, followed by a wait until the synchronized clock line really reads high. A slave that stretches the clock by holding it low therefore pauses the engine and cannot corrupt the data.

Top module: `i2cm_engine`

## Requirements
- R1: After reset, both pull-low enables are inactive (both lines released), busy is low and done is low.
- R2: A start primitive releases data, then releases clock, then pulls data low while the clock line is high, then pulls the clock low.
- R3: A stop primitive pulls data low while the clock is low, then releases the clock, then releases data while the clock line is high. Afterwards both lines read high.
- R4: A write primitive sends its eight data bits most significant bit first, one clock pulse per bit. Data changes only while the clock is low, so no start or stop condition can appear inside a byte.
- R5: During the ninth clock of a write, the engine releases data and samples the slave's level while the clock is high. ackSeen then holds that level: 0 means acknowledge, 1 means no acknowledge.
- R6: During a read, the engine releases data for all eight data bits. It samples each bit after the clock reads high and presents the byte, most significant bit first, on rxData when done pulses.
- R7: During the ninth clock of a read, the engine pulls data low when cmdAck is 1 (acknowledge). It leaves data released when cmdAck is 0 (no acknowledge).
- R8: After releasing the clock, the engine starts timing the high phase only once the synchronized clock reads high. An unstretched high phase inside a byte lasts 2*(quarterDiv+1)+3 cycles. A stretched one never lasts fewer than 2*(quarterDiv+1) cycles after the line rises. The engine never pulls the clock low while the clock line is still low after a release.
- R9: Inside a byte, the clock low phase between consecutive bits lasts exactly 2*(quarterDiv+1) cycles when no slave holds the clock.
- R10: cmdOp encodes 0 = start, 1 = stop, 2 = write, 3 = read. A command is taken only when cmdValid is high and busy is low, and busy is high in the following cycle. A command offered while busy is high has no effect. Done is a single-cycle pulse, and busy is low in the cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command offer strobe |
| cmdOp | input | 2 | Primitive code |
| cmdData | input | DATA_W | Byte to write |
| cmdAck | input | 1 | Read only: 1 returns acknowledge, 0 returns no acknowledge |
| quarterDiv | input | DIV_W | Quarter-bit period minus one, in clocks |
| busy | output | 1 | Primitive in progress |
| done | output | 1 | One-cycle completion pulse |
| rxData | output | DATA_W | Last byte read |
| ackSeen | output | 1 | Acknowledge level seen on the last write |
| sclIn | input | 1 | Clock line level |
| sdaIn | input | 1 | Data line level |
| sclPullLow | output | 1 | Pull clock line low when 1 |
| sdaPullLow | output | 1 | Pull data line low when 1 |

## Verification
The bench attaches a slave model that can hold the clock low for far longer than a bit period. A design that timed the high phase from its own release, instead of from the line reading high, would then sample read data before the slave drove it, and the returned bytes would differ.

A bus decoder watches for data edges while the clock is high. If the engine moved data at the wrong time inside a byte, the decoder would report a spurious start or stop.

Further runs cover:
- writes that are acknowledged and writes that are not, so that inverted acknowledge handling shows up;
- reads that end with acknowledge and with no acknowledge;
- a repeated start issued right after a byte;
- a divider of zero, where an off-by-one in the quarter counter changes every measured phase length;
- a command offered while busy, which a design without the busy gate would execute as an extra bus event and an extra done pulse.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } opCode_t;

  // Strobes from control to datapath, at most a few per cycle.
  typedef struct packed {
    logic tmrStart;   // load quarter timer
    logic sclPull;    // pull clock low
    logic sclFree;    // release clock
    logic sdaPull;    // pull data low
    logic sdaFree;    // release data
    logic sdaBit;     // drive data for current bit slot
    logic loadCmd;    // capture command fields
    logic sampleSda;  // sample data and advance bit slot
  } ctlStrobe_t;

endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [1:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              cmdAck,
  input  logic [DIV_W-1:0]  quarterDiv,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclHigh,
  output logic              qDone,
  output logic              lastBit,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  output logic [DATA_W-1:0] rxData,
  output logic              ackSeen
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] DATA_SLOTS = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ALL_SLOTS  = CNT_W'(DATA_W + 1);

  // Input synchronizers, reset to the released (high) level.
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end
  endgenerate

  logic sdaLevel;
  assign sclHigh  = sclSync[SYNC_STAGES-1];
  assign sdaLevel = sdaSync[SYNC_STAGES-1];

  // Quarter-bit timer: one period is quarterDiv+1 cycles.
  logic [DIV_W-1:0] tmrCnt;
  logic             tmrRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt <= '0;
      tmrRun <= 1'b0;
    end else if (strobe.tmrStart) begin
      tmrCnt <= quarterDiv;
      tmrRun <= 1'b1;
    end else if (tmrRun) begin
      if (tmrCnt == '0) tmrRun <= 1'b0;
      else              tmrCnt <= tmrCnt - 1'b1;
    end
  end

  assign qDone = tmrRun && (tmrCnt == '0);

  // Byte shifter and slot counter.
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitIdx;
  logic              isRead;
  logic              ackLow;
  logic              dataSlot;

  assign dataSlot = bitIdx < DATA_SLOTS;
  assign lastBit  = bitIdx == ALL_SLOTS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitIdx   <= '0;
      isRead   <= 1'b0;
      ackLow   <= 1'b0;
      rxData   <= '0;
      ackSeen  <= 1'b0;
    end else begin
      if (strobe.loadCmd) begin
        shiftReg <= cmdData;
        bitIdx   <= '0;
        isRead   <= opCode_t'(cmdOp) == OP_READ;
        ackLow   <= cmdAck;
      end
      if (strobe.sampleSda) begin
        bitIdx <= bitIdx + 1'b1;
        if (dataSlot) begin
          shiftReg <= {shiftReg[DATA_W-2:0], sdaLevel};
        end else if (isRead) begin
          rxData <= shiftReg;
        end else begin
          ackSeen <= sdaLevel;
        end
      end
    end
  end

  // Line pull-low enables.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPullLow <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      if (strobe.sclPull)      sclPullLow <= 1'b1;
      else if (strobe.sclFree) sclPullLow <= 1'b0;

      if (strobe.sdaPull)      sdaPullLow <= 1'b1;
      else if (strobe.sdaFree) sdaPullLow <= 1'b0;
      else if (strobe.sdaBit) begin
        if (dataSlot) sdaPullLow <= !isRead && !shiftReg[DATA_W-1];
        else          sdaPullLow <= isRead && ackLow;
      end
    end
  end

endmodule

// File: rtl/i2cm_control.sv
module i2cm_control
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       qDone,
  input  logic       sclHigh,
  input  logic       lastBit,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       inByte
);

  typedef enum logic [3:0] {
    S_IDLE, S_ST_SDA, S_ST_SCL, S_ST_FALL, S_ST_END,
    S_SP_SDA, S_SP_SCL, S_SP_END,
    S_LOAD, S_BIT_SET, S_BIT_HI, S_BIT_HOLD, S_BIT_LO
  } state_t;

  state_t state, nextState;
  logic   waitHi, nextWait, nextDone;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextWait  = waitHi;
    nextDone  = 1'b0;
    if (waitHi) begin
      // Clock released: time the high phase only once it reads high.
      if (sclHigh) begin
        strobe.tmrStart = 1'b1;
        nextWait        = 1'b0;
      end
    end else begin
      case (state)
        S_IDLE: if (cmdValid) begin
          case (opCode_t'(cmdOp))
            OP_START: begin
              strobe.sdaFree  = 1'b1;
              strobe.tmrStart = 1'b1;
              nextState       = S_ST_SDA;
            end
            OP_STOP: begin
              strobe.sdaPull  = 1'b1;
              strobe.tmrStart = 1'b1;
              nextState       = S_SP_SDA;
            end
            default: begin
              strobe.loadCmd = 1'b1;
              nextState      = S_LOAD;
            end
          endcase
        end
        S_ST_SDA: if (qDone) begin
          strobe.sclFree = 1'b1;
          nextWait       = 1'b1;
          nextState      = S_ST_SCL;
        end
        S_ST_SCL: if (qDone) begin
          strobe.sdaPull  = 1'b1;
          strobe.tmrStart = 1'b1;
          nextState       = S_ST_FALL;
        end
        S_ST_FALL: if (qDone) begin
          strobe.sclPull  = 1'b1;
          strobe.tmrStart = 1'b1;
          nextState       = S_ST_END;
        end
        S_ST_END: if (qDone) begin
          nextDone  = 1'b1;
          nextState = S_IDLE;
        end
        S_SP_SDA: if (qDone) begin
          strobe.sclFree = 1'b1;
          nextWait       = 1'b1;
          nextState      = S_SP_SCL;
        end
        S_SP_SCL: if (qDone) begin
          strobe.sdaFree  = 1'b1;
          strobe.tmrStart = 1'b1;
          nextState       = S_SP_END;
        end
        S_SP_END: if (qDone) begin
          nextDone  = 1'b1;
          nextState = S_IDLE;
        end
        S_LOAD: begin
          strobe.sdaBit   = 1'b1;
          strobe.tmrStart = 1'b1;
          nextState       = S_BIT_SET;
        end
        S_BIT_SET: if (qDone) begin
          strobe.sclFree = 1'b1;
          nextWait       = 1'b1;
          nextState      = S_BIT_HI;
        end
        S_BIT_HI: if (qDone) begin
          strobe.sampleSda = 1'b1;
          strobe.tmrStart  = 1'b1;
          nextState        = S_BIT_HOLD;
        end
        S_BIT_HOLD: if (qDone) begin
          strobe.sclPull  = 1'b1;
          strobe.tmrStart = 1'b1;
          nextState       = S_BIT_LO;
        end
        S_BIT_LO: if (qDone) begin
          if (lastBit) begin
            strobe.sdaFree = 1'b1;
            nextDone       = 1'b1;
            nextState      = S_IDLE;
          end else begin
            strobe.sdaBit   = 1'b1;
            strobe.tmrStart = 1'b1;
            nextState       = S_BIT_SET;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      waitHi <= 1'b0;
      done   <= 1'b0;
    end else begin
      state  <= nextState;
      waitHi <= nextWait;
      done   <= nextDone;
    end
  end

  assign busy   = state != S_IDLE;
  assign inByte = (state == S_LOAD) || (state == S_BIT_SET) || (state == S_BIT_HI) ||
                  (state == S_BIT_HOLD) || (state == S_BIT_LO);

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              cmdAck,
  input  logic [DIV_W-1:0]  quarterDiv,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxData,
  output logic              ackSeen,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow
);

  ctlStrobe_t ctlStrobe;
  logic       qDone, sclHigh, lastBit, ctlInByte;

  i2cm_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .qDone    (qDone),
    .sclHigh  (sclHigh),
    .lastBit  (lastBit),
    .strobe   (ctlStrobe),
    .busy     (busy),
    .done     (done),
    .inByte   (ctlInByte)
  );

  i2cm_datapath #(
    .DATA_W      (DATA_W),
    .DIV_W       (DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (ctlStrobe),
    .cmdOp      (cmdOp),
    .cmdData    (cmdData),
    .cmdAck     (cmdAck),
    .quarterDiv (quarterDiv),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .sclHigh    (sclHigh),
    .qDone      (qDone),
    .lastBit    (lastBit),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow),
    .rxData     (rxData),
    .ackSeen    (ackSeen)
  );

endmodule

// File: rtl/i2cm_engine_chk.sv
module i2cm_engine_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic busy,
  input logic done,
  input logic sclPullLow,
  input logic sdaPullLow,
  input logic sclIn,
  input logic inByte
);

  assert_lines_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!sclPullLow && !sdaPullLow && !busy && !done));

  // Inside a byte, data must hold while the clock stays released.
  assert_sda_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inByte && !sclPullLow && !$past(sclPullLow)) |-> $stable(sdaPullLow));

  // A released clock still read low is never pulled low again.
  assert_scl_wait_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!sclPullLow && !sclIn) |=> !sclPullLow);

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind i2cm_engine i2cm_engine_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .busy       (busy),
  .done       (done),
  .sclPullLow (sclPullLow),
  .sdaPullLow (sdaPullLow),
  .sclIn      (sclIn),
  .inByte     (ctlInByte)
);

// File: tb/i2cm_engine_tb_top.sv
module i2cm_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OPC_START = 0, OPC_STOP = 1, OPC_WRITE = 2, OPC_READ = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [7:0]  cmdData = 8'h00;
  logic        cmdAck = 1'b0;
  logic [15:0] quarterDiv = 16'd3;
  logic        busy, done, ackSeen, sclPullLow, sdaPullLow;
  logic [7:0]  rxData;
  logic        slaveSclHold = 1'b0;
  logic        slaveSdaLow = 1'b0;
  int          stretchCycles = 0;

  wire sclLine = ~(sclPullLow | slaveSclHold);
  wire sdaLine = ~(sdaPullLow | slaveSdaLow);

  i2cm_engine dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
    .cmdAck(cmdAck), .quarterDiv(quarterDiv), .busy(busy), .done(done),
    .rxData(rxData), .ackSeen(ackSeen), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard queues.
  int expKind[$];
  int expByte[$];
  int expAckBit[$];
  int doneOp[$];
  int doneVal[$];

  task automatic busEvent(input int kind, input int data, input int ackb);
    if (expKind.size() == 0) begin
      chk(1'b0, "R2 R3 R4 unexpected bus event", kind, -1);
    end else begin
      int k, b, a;
      k = expKind.pop_front();
      b = expByte.pop_front();
      a = expAckBit.pop_front();
      chk(k == kind, "R2 R3 R4 bus event kind", kind, k);
      if (k == 2 && kind == 2) begin
        chk(b == data, "R4 R6 byte on bus", data, b);
        chk(a == ackb, "R5 R7 acknowledge bit on bus", ackb, a);
      end
    end
  endtask

  // Bus decoder.
  int         monBits = 0;
  logic [8:0] monShift = '0;

  always @(negedge sdaLine) if (rstN && sclLine) begin
    monBits = 0;
    busEvent(0, 0, 0);
  end
  always @(posedge sdaLine) if (rstN && sclLine) begin
    monBits = 0;
    busEvent(1, 0, 0);
  end
  always @(posedge sclLine) if (rstN) begin
    monShift = {monShift[7:0], sdaLine};
    monBits  = (monBits == 9) ? 1 : monBits + 1;
    if (monBits == 9) busEvent(2, int'(monShift[8:1]), int'(monShift[0]));
  end

  // Slave responder: data per bit slot, optional clock stretch on every fall.
  logic [8:0] respBits = '0;
  int         respIdx = 0;
  bit         respActive = 1'b0;

  always @(negedge sclLine) if (rstN && respActive) begin
    respIdx++;
    if (respIdx < 9) slaveSdaLow = respBits[respIdx];
    else begin
      slaveSdaLow = 1'b0;
      respActive  = 1'b0;
    end
  end

  always @(negedge sclLine) if (rstN && stretchCycles > 0) begin
    slaveSclHold = 1'b1;
    repeat (stretchCycles) @(negedge clk);
    slaveSclHold = 1'b0;
  end

  // Phase width monitor (R8, R9).
  logic prevScl = 1'b1;
  int   runLen = 0;
  always @(negedge clk) if (rstN) begin
    if (sclLine !== prevScl) begin
      if (!prevScl && monBits >= 2 && monBits <= 9) begin
        if (stretchCycles == 0)
          chk(runLen == 2 * (quarterDiv + 1), "R9 low phase length", runLen, 2 * (quarterDiv + 1));
        else
          chk(runLen >= 2 * (quarterDiv + 1), "R9 stretched low phase", runLen, 2 * (quarterDiv + 1));
      end
      if (prevScl && monBits >= 1 && monBits <= 9) begin
        if (stretchCycles == 0)
          chk(runLen == 2 * (quarterDiv + 1) + 3, "R8 high phase length", runLen, 2 * (quarterDiv + 1) + 3);
        else
          chk(runLen >= 2 * (quarterDiv + 1), "R8 stretched high phase", runLen, 2 * (quarterDiv + 1));
      end
      runLen  = 1;
      prevScl = sclLine;
    end else begin
      runLen++;
    end
  end

  // Completion monitor.
  logic prevDone = 1'b0;
  always @(negedge clk) if (rstN) begin
    if (done) begin
      chk(!prevDone, "R10 done wider than one cycle", 1, 0);
      chk(!busy, "R10 busy low with done", busy, 0);
      if (doneOp.size() == 0) begin
        chk(1'b0, "R10 unexpected done", 1, 0);
      end else begin
        int op, v;
        op = doneOp.pop_front();
        v  = doneVal.pop_front();
        if (op == OPC_WRITE) chk(ackSeen == v[0], "R5 ackSeen after write", ackSeen, v);
        if (op == OPC_READ)  chk(rxData == v[7:0], "R6 rxData after read", rxData, v);
      end
    end
    prevDone = done;
  end

  task automatic runCmd(input int op, input int data, input bit ackFlag, input bit poke);
    while (busy) @(negedge clk);
    doneOp.push_back(op);
    case (op)
      OPC_START: begin
        expKind.push_back(0); expByte.push_back(0); expAckBit.push_back(0);
        doneVal.push_back(0);
      end
      OPC_STOP: begin
        expKind.push_back(1); expByte.push_back(0); expAckBit.push_back(0);
        doneVal.push_back(0);
      end
      OPC_WRITE: begin
        expKind.push_back(2); expByte.push_back(data); expAckBit.push_back(ackFlag ? 0 : 1);
        doneVal.push_back(ackFlag ? 0 : 1);
        respBits = {ackFlag, 8'h00};
      end
      default: begin
        expKind.push_back(2); expByte.push_back(data); expAckBit.push_back(ackFlag ? 0 : 1);
        doneVal.push_back(data);
        for (int i = 0; i < 8; i++) respBits[i] = ~data[7-i];
        respBits[8] = 1'b0;
      end
    endcase
    if (op == OPC_WRITE || op == OPC_READ) begin
      respIdx     = 0;
      slaveSdaLow = respBits[0];
      respActive  = 1'b1;
    end
    cmdValid = 1'b1;
    cmdOp    = 2'(op);
    cmdData  = (op == OPC_WRITE) ? 8'(data) : 8'hA5;
    cmdAck   = (op == OPC_READ) ? ackFlag : 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(busy, "R10 busy after accept", busy, 1);
    if (poke) begin
      // Offered while busy: must be ignored (R10).
      repeat (5) @(negedge clk);
      cmdValid = 1'b1;
      cmdOp    = 2'(OPC_STOP);
      @(negedge clk);
      cmdValid = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!sclPullLow, "R1 clock released", sclPullLow, 0);
    chk(!sdaPullLow, "R1 data released", sdaPullLow, 0);
    chk(!busy, "R1 busy low", busy, 0);
    chk(!done, "R1 done low", done, 0);

    // Writes with and without slave acknowledge.
    runCmd(OPC_START, 0, 1'b0, 1'b0);
    runCmd(OPC_WRITE, 8'hA6, 1'b1, 1'b0);
    runCmd(OPC_WRITE, 8'h3C, 1'b0, 1'b0);
    runCmd(OPC_STOP, 0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(sclLine && sdaLine, "R3 lines high after stop", {sclLine, sdaLine}, 3);

    // Repeated start and reads with both acknowledge choices.
    runCmd(OPC_START, 0, 1'b0, 1'b0);
    runCmd(OPC_WRITE, 8'h5A, 1'b1, 1'b0);
    runCmd(OPC_START, 0, 1'b0, 1'b0);
    runCmd(OPC_WRITE, 8'h5B, 1'b1, 1'b0);
    runCmd(OPC_READ, 8'hC3, 1'b1, 1'b0);
    runCmd(OPC_READ, 8'h1E, 1'b0, 1'b0);
    runCmd(OPC_STOP, 0, 1'b0, 1'b0);

    // Minimum divider.
    quarterDiv = 16'd0;
    runCmd(OPC_START, 0, 1'b0, 1'b0);
    runCmd(OPC_WRITE, 8'hFF, 1'b1, 1'b0);
    runCmd(OPC_READ, 8'h00, 1'b0, 1'b0);
    runCmd(OPC_STOP, 0, 1'b0, 1'b0);

    // Clock stretching by the slave.
    quarterDiv    = 16'd3;
    stretchCycles = 30;
    runCmd(OPC_START, 0, 1'b0, 1'b0);
    runCmd(OPC_READ, 8'h96, 1'b1, 1'b0);
    runCmd(OPC_WRITE, 8'h81, 1'b1, 1'b0);
    runCmd(OPC_STOP, 0, 1'b0, 1'b0);
    while (slaveSclHold) @(negedge clk);
    stretchCycles = 0;

    // Command offered while busy must do nothing.
    runCmd(OPC_START, 0, 1'b0, 1'b0);
    runCmd(OPC_WRITE, 8'h69, 1'b1, 1'b1);
    repeat (60) @(negedge clk);
    chk(!busy, "R10 ignored command left engine idle", busy, 0);
    chk(sclLine == 1'b0, "R10 ignored command left clock low", sclLine, 0);
    runCmd(OPC_STOP, 0, 1'b0, 1'b0);

    repeat (20) @(negedge clk);
    chk(expKind.size() == 0, "R4 pending bus events", expKind.size(), 0);
    chk(doneOp.size() == 0, "R10 pending completions", doneOp.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule